// File: doc/BRIEF.md
# Carry-Select Adder with Increment-Based Upper Groups

This block adds two unsigned operands and a carry input in pure combinational logic, returning the sum and a carry output. The operand width is a parameter (16 by default). The bit positions are split into groups of unequal width. The least significant group is a plain ripple-carry adder fed by the external carry. Every higher group computes its result only once, assuming no incoming carry. It then forms the result for an incoming carry by adding one to that value with a small increment network. The carry arriving from the group below chooses which of the two results leaves the group. That selected carry then steers the next group.

Group widths grow from the bottom of the word. The first two groups are 2 bits wide, and group g (counting from zero, g >= 2) is g+1 bits wide. The last group is cut to fit the word. At 16 bits this gives 2, 2, 3, 4 and 5 bits. The same rule gives the 32-bit and 64-bit versions with no other change.

Top module: `csel_adder`

## Requirements
- R1: For every value of op_a, op_b and carry_in, the concatenation {carry_out, sum} equals op_a + op_b + carry_in computed at WIDTH+1 bits.
- R2: sum[1:0] equals the low two bits of op_a[1:0] + op_b[1:0] + carry_in. This is the base ripple group, the only group that sees the external carry directly.
- R3: The increment network of width N returns its input plus one modulo 2^N. Bit 0 is inverted, and bit i is flipped exactly when all lower input bits are 1, so an all-ones input yields all zeros.
- R4: At WIDTH=16 the groups cover bits [1:0], [3:2], [6:4], [10:7] and [15:11]. Each group's sum slice equals its own operand slices plus the carry that the lower bits produce: the no-carry result when that carry is 0, and the incremented result when it is 1.
- R5: carry_out equals the carry leaving the top group, which is bit WIDTH of the full-precision sum.
- R6: With both operands all ones and carry_in = 1, sum is all ones and carry_out is 1.
- R7: With both operands zero, sum equals carry_in in bit 0 (zero elsewhere) and carry_out is 0.
- R8: With op_a all ones, op_b zero and carry_in = 1, a carry crosses every group boundary, giving sum = 0 and carry_out = 1.
- R9: With WIDTH set to 32 or 64, the grouping rule still applies, and the output still meets the full-precision equality of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Incoming carry, added at bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry leaving the most significant group |

## Verification
The hardest case to reach from the ports is a group whose incoming carry is set while its own no-carry result is all ones. In that case the increment network must wrap and pass its carry on to the next group. Random operands rarely reach this state in the upper, wider groups. The stimulus therefore walks every bit position with a run of ones in op_a just below it, plus a single one in op_b, so that each group boundary receives a carry both from inside a full group and from its edge. An exhaustive sweep over the low six bits of both operands and the carry, under four fixed upper-bit patterns, covers every select combination of the lower three groups.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Nominal width of group g before trimming to the word size.
    function automatic int grp_width_raw(input int g);
        return (g < 2) ? 2 : g + 1;
    endfunction

    // Lowest bit position covered by group g.
    function automatic int grp_lsb(input int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++) acc += grp_width_raw(i);
        return acc;
    endfunction

    // Number of groups needed to cover total bits.
    function automatic int grp_count(input int total);
        int covered;
        int n;
        covered = 0;
        n = 0;
        while (covered < total) begin
            covered += grp_width_raw(n);
            n++;
        end
        return n;
    endfunction

    // Width of group g after trimming the last group to fit.
    function automatic int grp_width(input int g, input int total);
        int w;
        w = grp_width_raw(g);
        if (grp_lsb(g) + w > total) w = total - grp_lsb(g);
        return w;
    endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int K = 2
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    input  logic         cin,
    output logic [K-1:0] sum,
    output logic         cout
);
    logic [K:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < K; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[K];
endmodule

// File: rtl/csel_excess1.sv
module csel_excess1 #(
    parameter int N = 3
) (
    input  logic [N-1:0] val_in,
    output logic [N-1:0] val_out
);
    // ones_below[i] is set when every input bit below i is 1.
    logic [N-1:0] ones_below;

    assign ones_below[0] = 1'b1;

    for (genvar i = 1; i < N; i++) begin : g_run
        assign ones_below[i] = ones_below[i-1] & val_in[i-1];
    end

    for (genvar i = 0; i < N; i++) begin : g_flip
        assign val_out[i] = val_in[i] ^ ones_below[i];
    end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int K = 2
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    input  logic         sel,
    output logic [K-1:0] sum,
    output logic         cout
);
    logic [K-1:0] zero_sum;
    logic         zero_cy;
    logic [K:0]   plus_one;

    csel_ripple #(.K(K)) u_rca (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (zero_sum),
        .cout (zero_cy)
    );

    csel_excess1 #(.N(K + 1)) u_inc (
        .val_in  ({zero_cy, zero_sum}),
        .val_out (plus_one)
    );

    assign {cout, sum} = sel ? plus_one : {zero_cy, zero_sum};
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int NGRP = csel_pkg::grp_count(WIDTH);

    // carry[g] is the carry entering group g.
    logic [NGRP:0] carry;

    assign carry[0] = carry_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LSB = csel_pkg::grp_lsb(g);
        localparam int W   = csel_pkg::grp_width(g, WIDTH);
        if (g == 0) begin : g_base
            csel_ripple #(.K(W)) u_base (
                .a    (op_a[LSB +: W]),
                .b    (op_b[LSB +: W]),
                .cin  (carry[g]),
                .sum  (sum[LSB +: W]),
                .cout (carry[g+1])
            );
        end else begin : g_sel
            csel_group #(.K(W)) u_grp (
                .a    (op_a[LSB +: W]),
                .b    (op_b[LSB +: W]),
                .sel  (carry[g]),
                .sum  (sum[LSB +: W]),
                .cout (carry[g+1])
            );
        end
    end

    assign carry_out = carry[NGRP];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    logic [WIDTH:0] ref_total;
    logic [2:0]     ref_low;

    always_comb begin
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        ref_low   = {1'b0, op_a[1:0]} + {1'b0, op_b[1:0]} + {2'b00, carry_in};
    end

    always_comb begin
        AST_SUM_EXACT: assert ({carry_out, sum} == ref_total) else $error("sum mismatch"); // R1
        AST_LOW_GROUP: assert (sum[1:0] == ref_low[1:0]) else $error("low group mismatch"); // R2
        AST_CARRY_TOP: assert (carry_out == ref_total[WIDTH]) else $error("carry out mismatch"); // R5
        if (&op_a && &op_b && carry_in) begin
            AST_ALL_ONES: assert (&sum && carry_out) else $error("all ones case"); // R6
        end
        if (op_a == '0 && op_b == '0) begin
            AST_ZERO_IN: assert (sum == {{(WIDTH-1){1'b0}}, carry_in} && !carry_out) else $error("zero case"); // R7
        end
        if (&op_a && op_b == '0 && carry_in) begin
            AST_FULL_CHAIN: assert (sum == '0 && carry_out) else $error("full chain case"); // R8
        end
    end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/csel_adder_tb.sv
module csel_adder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [15:0] a16 = '0, b16 = '0, s16;
    logic        c16 = 1'b0, co16;
    logic [31:0] a32 = '0, b32 = '0, s32;
    logic        c32 = 1'b0, co32;
    logic [63:0] a64 = '0, b64 = '0, s64;
    logic        c64 = 1'b0, co64;
    logic [3:0]  e4_in = '0, e4_out;
    logic [5:0]  e6_in = '0, e6_out;

    csel_adder #(.WIDTH(16)) dut_i (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));
    csel_adder #(.WIDTH(32)) dut32_i (
        .op_a(a32), .op_b(b32), .carry_in(c32), .sum(s32), .carry_out(co32));
    csel_adder #(.WIDTH(64)) dut64_i (
        .op_a(a64), .op_b(b64), .carry_in(c64), .sum(s64), .carry_out(co64));
    csel_excess1 #(.N(4)) inc4_i (.val_in(e4_in), .val_out(e4_out));
    csel_excess1 #(.N(6)) inc6_i (.val_in(e6_in), .val_out(e6_out));

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic check(input bit ok, input string req, input logic [64:0] act,
                         input logic [64:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Group layout for WIDTH=16 as stated in R4.
    int glsb [5] = '{0, 2, 4, 7, 11};
    int gwid [5] = '{2, 2, 3, 4, 5};

    task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c,
                           input string req);
        logic [16:0] exp;
        bit grp_ok;
        @(posedge clk);
        a16 <= a; b16 <= b; c16 <= c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
        check({co16, s16} == exp, req, {co16, s16}, exp);
        check(s16[1:0] == exp[1:0], "R2", s16[1:0], exp[1:0]);
        check(co16 == exp[16], "R5", co16, exp[16]);
        grp_ok = 1'b1;
        for (int g = 0; g < 5; g++) begin
            int lo_sum, cin_g, slice;
            int m;
            m = (1 << gwid[g]) - 1;
            lo_sum = (int'(a) & ((1 << glsb[g]) - 1)) + (int'(b) & ((1 << glsb[g]) - 1)) + int'(c);
            cin_g = lo_sum >> glsb[g];
            slice = (((int'(a) >> glsb[g]) & m) + ((int'(b) >> glsb[g]) & m) + cin_g) & m;
            if (((int'(s16) >> glsb[g]) & m) != slice) grp_ok = 1'b0;
        end
        check(grp_ok, "R4 group slice", s16, exp);
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] exp;
        @(posedge clk);
        a32 <= a; b32 <= b; c32 <= c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
        check({co32, s32} == exp, "R9 width32", {co32, s32}, exp);
    endtask

    task automatic apply64(input logic [63:0] a, input logic [63:0] b, input logic c);
        logic [64:0] exp;
        @(posedge clk);
        a64 <= a; b64 <= b; c64 <= c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {64'd0, c};
        check({co64, s64} == exp, "R9 width64", {co64, s64}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] hi_pat [4] = '{16'h0000, 16'hFFC0, 16'hAAC0, 16'h5540};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(s16 == 16'd0 && co16 == 1'b0, "R7 reset state", {co16, s16}, 17'd0);

        // R3: increment networks, exhaustive.
        for (int v = 0; v < 16; v++) begin
            @(posedge clk); e4_in <= 4'(v);
            @(negedge clk);
            check(e4_out == 4'(v + 1), "R3 inc4", e4_out, 4'(v + 1));
        end
        for (int v = 0; v < 64; v++) begin
            @(posedge clk); e6_in <= 6'(v);
            @(negedge clk);
            check(e6_out == 6'(v + 1), "R3 inc6", e6_out, 6'(v + 1));
        end

        // Corner cases R6, R7, R8.
        apply16(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones");
        apply16(16'h0000, 16'h0000, 1'b0, "R7 zero");
        apply16(16'h0000, 16'h0000, 1'b1, "R7 zero cin");
        apply16(16'hFFFF, 16'h0000, 1'b1, "R8 full chain");
        apply16(16'h0000, 16'hFFFF, 1'b1, "R8 full chain swapped");

        // Carry arriving at every bit position (R4 boundaries).
        for (int p = 1; p <= 16; p++) begin
            logic [16:0] run;
            run = (17'd1 << p) - 17'd1;
            apply16(run[15:0], 16'd1, 1'b0, "R1 carry walk");
            apply16(run[15:0], 16'd0, 1'b1, "R1 carry walk cin");
            apply16(run[15:0], ~run[15:0], 1'b1, "R1 complement walk");
        end

        // Near-exhaustive sweep of the low three groups.
        for (int h = 0; h < 4; h++)
            for (int x = 0; x < 64; x++)
                for (int y = 0; y < 64; y++)
                    for (int c = 0; c < 2; c++)
                        apply16(hi_pat[h] | 16'(x), ~hi_pat[h] & 16'hFFC0 | 16'(y),
                                1'(c), "R1 sweep");

        // Random patterns.
        for (int i = 0; i < 20000; i++)
            apply16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");

        // Wider versions.
        apply32('1, '1, 1'b1);
        apply32('1, '0, 1'b1);
        apply32('0, '0, 1'b0);
        apply64('1, '1, 1'b1);
        apply64('1, '0, 1'b1);
        apply64('0, '0, 1'b1);
        for (int p = 1; p <= 64; p++) begin
            logic [64:0] run;
            run = (65'd1 << p) - 65'd1;
            apply64(run[63:0], 64'd1, 1'b0);
            if (p <= 32) apply32(run[31:0], 32'd0, 1'b1);
        end
        for (int i = 0; i < 3000; i++) begin
            apply32($urandom, $urandom, 1'($urandom));
            apply64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule